// File: doc/BRIEF.md
# Debug Data Register Front-End with Autoexec

This block is the register front-end of a processor debug module. A host reaches it over a simple debug module interface (DMI). The interface has an address, a read strobe and a write strobe, a 32-bit write data bus and a 32-bit read data bus.

The block stores the following:
- a small bank of abstract data words;
- a program buffer;
- the last command word;
- a control/status word, which holds an eight-bit autoexec mask, a busy flag and an error code.

When a command has to run, the block sends a one-cycle start pulse to an external executor. It then waits for that executor's done and error signals. A command runs in two cases: the host writes the command register, or the host touches a data word whose autoexec bit is set. In the second case the last latched command runs again. This lets the host stream data through one data word, with a command running after each access. While an error code is pending, no command starts.

Top module: `dbg_regfront`

## Requirements
- R1: After a synchronous active-low reset, all of the following read zero: every data word, every program buffer word, the command word and the control/status word. `exec_start` is low.
- R2: Data word i is at address DATA_BASE+i (default 0x04) for i < NDATA (default 4) and is readable and writable there. Addresses past the last data word read zero, ignore writes and never start a command.
- R3: Program buffer word i is at address PBUF_BASE+i (default 0x20) for i < PBUF_WORDS (default 8). Addresses past it read zero. An access to the program buffer never starts a command, whatever the autoexec mask holds.
- R4: A write to the command register (address 0x17) stores the written value, and `exec_cmd` shows that value. `exec_start` is high for exactly the one cycle that follows the write.
- R5: A read or a write of data word i while autoexec mask bit i is set starts the stored command. The start pulse comes in the cycle after the access. A read returns the word as it was in the access cycle.
- R6: A write to the control/status register (address 0x16) loads the autoexec mask from bits [23:16] of the written value. A read returns the mask at bits [23:16], the busy flag at bit 12 and the error code at bits [2:0].
- R7: The busy flag is set from a start until `exec_done`. A start request that arrives while busy sets the error code to 1 (busy error) and does not pulse `exec_start`.
- R8: While the error code is non-zero, no start request (from the command register or from autoexec) pulses `exec_start`.
- R9: The error code is write-one-to-clear. Each 1 written to bits [2:0] of the control/status register clears that error bit, and each 0 leaves its bit unchanged.
- R10: `exec_done` together with `exec_err` while busy sets the error code to 2 (execution error).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dmi_addr | input | ADDR_W | Register address |
| dmi_rd | input | 1 | Read strobe |
| dmi_wr | input | 1 | Write strobe |
| dmi_wdata | input | 32 | Write data |
| dmi_rdata | output | 32 | Read data, valid in the cycle `dmi_rd` is high |
| exec_start | output | 1 | One-cycle command start pulse to the executor |
| exec_cmd | output | 32 | Latched command word |
| exec_done | input | 1 | Executor finished the running command |
| exec_err | input | 1 | Qualifies `exec_done` as a failed run |

## Verification
The bench walks the edges of both address windows, the first and last word of each and the word just past each. A decoder that was off by one would store or return a word where none exists. It sets autoexec bits above NDATA and then touches the program buffer and an out-of-range data address. A decoder that leaked autoexec into those spaces would pulse a start. It re-issues a command while one is busy, and then issues one while the error is pending. A design that checked only one of those conditions would start a second run. It also clears only one error bit that is not set, and a plain write-to-clear would then wipe the execution error.

// File: rtl/dbgfe_pkg.sv
// Package: shared constants for the debug register front-end.
// Assumes a 32-bit DMI data path.
package dbgfe_pkg;
    localparam int WORD_W   = 32;
    localparam int MASK_W   = 8;
    localparam int MASK_LSB = 16;
    localparam int BUSY_BIT = 12;
    localparam int ERR_W    = 3;

    localparam logic [ERR_W-1:0] ERR_NONE = 3'd0;
    localparam logic [ERR_W-1:0] ERR_BUSY = 3'd1;
    localparam logic [ERR_W-1:0] ERR_EXEC = 3'd2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_PBUF,
        SEL_CS,
        SEL_CMD
    } sel_e;
endpackage

// File: rtl/dbg_addr_dec.sv
// Address decoder: maps a DMI address to a register space and a word index.
// Assumes the two windows and the two single registers do not overlap.
module dbg_addr_dec
    import dbgfe_pkg::*;
#(
    parameter int              ADDR_W     = 7,
    parameter int              NDATA      = 4,
    parameter int              PBUF_WORDS = 8,
    parameter int              IDX_W      = 3,
    parameter logic [ADDR_W-1:0] DATA_BASE = 7'h04,
    parameter logic [ADDR_W-1:0] PBUF_BASE = 7'h20,
    parameter logic [ADDR_W-1:0] CS_ADDR   = 7'h16,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 7'h17
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] data_off;
    logic [ADDR_W-1:0] pbuf_off;

    // Offsets into each window and selection of the space that was hit.
    always_comb begin
        data_off = addr - DATA_BASE;
        pbuf_off = addr - PBUF_BASE;
        sel      = SEL_NONE;
        idx      = '0;
        if (addr == CS_ADDR) begin
            sel = SEL_CS;
        end else if (addr == CMD_ADDR) begin
            sel = SEL_CMD;
        end else if (addr >= DATA_BASE && data_off < ADDR_W'(NDATA)) begin
            sel = SEL_DATA;
            idx = IDX_W'(data_off);
        end else if (addr >= PBUF_BASE && pbuf_off < ADDR_W'(PBUF_WORDS)) begin
            sel = SEL_PBUF;
            idx = IDX_W'(pbuf_off);
        end
    end
endmodule

// File: rtl/dbg_word_bank.sv
// Word bank: DEPTH words of 32 bits. It has one write port and one
// combinational read port. Assumes an index at or above DEPTH is guarded
// by the caller's decode; such an index reads zero here anyway.
module dbg_word_bank
    import dbgfe_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Hold one word; clear it on reset, load it when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '0;
            else if (we && int'(idx) == g)
                words[g] <= wdata;
        end
    end

    // Select the addressed word for reading.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < DEPTH; k++)
            if (int'(idx) == k) rdata = words[k];
    end
endmodule

// File: rtl/dbg_cmd_ctl.sv
// Command control: holds the command word, the autoexec mask, the error
// code and the busy flag. It decides when to pulse exec_start.
// Assumes that data_acc is high only for a data index below NDATA.
module dbg_cmd_ctl
    import dbgfe_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_we,
    input  logic              cmd_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              data_acc,
    input  logic [IDX_W-1:0]  data_idx,
    input  logic              exec_done,
    input  logic              exec_err,
    output logic [WORD_W-1:0] cmd_q,
    output logic [MASK_W-1:0] mask_q,
    output logic [ERR_W-1:0]  err_q,
    output logic              busy_q,
    output logic              start_q,
    output logic              start_req
);
    logic             auto_hit;
    logic             launch;
    logic             busy_nx;
    logic [ERR_W-1:0] err_nx;

    // Find out whether this cycle asks for a command to run.
    always_comb begin
        auto_hit  = data_acc && |(mask_q & (MASK_W'(1) << data_idx));
        start_req = cmd_we || auto_hit;
    end

    // Next error and busy state, and the start decision.
    always_comb begin
        err_nx  = cs_we ? (err_q & ~wdata[ERR_W-1:0]) : err_q;
        busy_nx = busy_q;
        launch  = 1'b0;
        if (busy_q && exec_done) begin
            busy_nx = 1'b0;
            if (exec_err) err_nx = ERR_EXEC;
        end
        if (start_req && err_q == ERR_NONE) begin
            if (busy_q) begin
                err_nx = ERR_BUSY;
            end else begin
                launch  = 1'b1;
                busy_nx = 1'b1;
            end
        end
    end

    // Register the state and the one-cycle start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            mask_q  <= '0;
            err_q   <= ERR_NONE;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            if (cmd_we) cmd_q <= wdata;
            if (cs_we)  mask_q <= wdata[MASK_LSB +: MASK_W];
            err_q   <= err_nx;
            busy_q  <= busy_nx;
            start_q <= launch;
        end
    end
endmodule

// File: rtl/dbg_regfront.sv
// Top level: the DMI register front-end. It holds the data words, the
// program buffer, the command word and the control/status word.
// Assumes one DMI access per cycle; a cycle with both strobes high is a write.
module dbg_regfront
    import dbgfe_pkg::*;
#(
    parameter int                ADDR_W     = 7,
    parameter int                NDATA      = 4,
    parameter int                PBUF_WORDS = 8,
    parameter logic [ADDR_W-1:0] DATA_BASE  = 7'h04,
    parameter logic [ADDR_W-1:0] PBUF_BASE  = 7'h20,
    parameter logic [ADDR_W-1:0] CS_ADDR    = 7'h16,
    parameter logic [ADDR_W-1:0] CMD_ADDR   = 7'h17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] dmi_addr,
    input  logic              dmi_rd,
    input  logic              dmi_wr,
    input  logic [31:0]       dmi_wdata,
    output logic [31:0]       dmi_rdata,
    output logic              exec_start,
    output logic [31:0]       exec_cmd,
    input  logic              exec_done,
    input  logic              exec_err
);
    localparam int MAXN  = (NDATA > PBUF_WORDS) ? NDATA : PBUF_WORDS;
    localparam int IDX_W = (MAXN > 1) ? $clog2(MAXN) : 1;

    sel_e              sel;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] data_rd, pbuf_rd, cmd_q;
    logic [MASK_W-1:0] mask_q;
    logic [ERR_W-1:0]  err_q;
    logic              busy_q, start_req;
    logic              data_we, pbuf_we, cs_we, cmd_we, data_acc;
    logic [WORD_W-1:0] cs_word;

    dbg_addr_dec #(
        .ADDR_W(ADDR_W), .NDATA(NDATA), .PBUF_WORDS(PBUF_WORDS), .IDX_W(IDX_W),
        .DATA_BASE(DATA_BASE), .PBUF_BASE(PBUF_BASE),
        .CS_ADDR(CS_ADDR), .CMD_ADDR(CMD_ADDR)
    ) u_dec (
        .addr(dmi_addr), .sel(sel), .idx(idx)
    );

    // Write enables for each space, and the data-access flag for autoexec.
    always_comb begin
        data_we  = dmi_wr && sel == SEL_DATA;
        pbuf_we  = dmi_wr && sel == SEL_PBUF;
        cs_we    = dmi_wr && sel == SEL_CS;
        cmd_we   = dmi_wr && sel == SEL_CMD;
        data_acc = (dmi_wr || dmi_rd) && sel == SEL_DATA;
    end

    dbg_word_bank #(.DEPTH(NDATA), .IDX_W(IDX_W)) u_data (
        .clk(clk), .rst_n(rst_n), .we(data_we), .idx(idx),
        .wdata(dmi_wdata), .rdata(data_rd)
    );

    dbg_word_bank #(.DEPTH(PBUF_WORDS), .IDX_W(IDX_W)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .we(pbuf_we), .idx(idx),
        .wdata(dmi_wdata), .rdata(pbuf_rd)
    );

    dbg_cmd_ctl #(.IDX_W(IDX_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .cs_we(cs_we), .cmd_we(cmd_we),
        .wdata(dmi_wdata), .data_acc(data_acc), .data_idx(idx),
        .exec_done(exec_done), .exec_err(exec_err),
        .cmd_q(cmd_q), .mask_q(mask_q), .err_q(err_q), .busy_q(busy_q),
        .start_q(exec_start), .start_req(start_req)
    );

    // Assemble the control/status word and drive the read mux.
    always_comb begin
        cs_word                       = '0;
        cs_word[MASK_LSB +: MASK_W]   = mask_q;
        cs_word[BUSY_BIT]             = busy_q;
        cs_word[ERR_W-1:0]            = err_q;
        dmi_rdata = '0;
        if (dmi_rd) begin
            unique case (sel)
                SEL_DATA: dmi_rdata = data_rd;
                SEL_PBUF: dmi_rdata = pbuf_rd;
                SEL_CS:   dmi_rdata = cs_word;
                SEL_CMD:  dmi_rdata = cmd_q;
                default:  dmi_rdata = '0;
            endcase
        end
    end

    assign exec_cmd = cmd_q;
endmodule

// File: rtl/dbg_regfront_chk.sv
// Checker: temporal properties of the command start and error logic.
// It is attached to dbg_regfront by the bind statement at the end of this file.
module dbg_regfront_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       exec_start,
    input logic       exec_done,
    input logic       exec_err,
    input logic       busy,
    input logic [2:0] err,
    input logic       start_req,
    input logic       cs_we
);
    // R1: reset clears the start pulse and the error code.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!exec_start && err == 3'd0));

    // R4: the start pulse lasts one cycle.
    a_r4_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> !exec_start);

    // R3: a start only follows a command write or an autoexec hit.
    a_r3_start_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |-> $past(start_req));

    // R7: no start while a command is running.
    a_r7_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |-> !$past(busy));

    // R8: no start while an error is pending.
    a_r8_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |-> $past(err) == 3'd0);

    // R10: a failed completion records the execution error.
    a_r10_exec_err: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && exec_done && exec_err && !start_req && !cs_we) |=> err == 3'd2);
endmodule

bind dbg_regfront dbg_regfront_chk u_chk (
    .clk(clk), .rst_n(rst_n), .exec_start(exec_start),
    .exec_done(exec_done), .exec_err(exec_err), .busy(busy_q),
    .err(err_q), .start_req(start_req), .cs_we(cs_we)
);

// File: tb/dbg_regfront_test.sv
// Bench for dbg_regfront: a vector table of accesses, then directed tests.
module dbg_regfront_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  dmi_addr = '0;
    logic        dmi_rd = 1'b0, dmi_wr = 1'b0;
    logic [31:0] dmi_wdata = '0;
    logic [31:0] dmi_rdata;
    logic        exec_start;
    logic [31:0] exec_cmd;
    logic        exec_done = 1'b0, exec_err = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    dbg_regfront uut (
        .clk(clk), .rst_n(rst_n), .dmi_addr(dmi_addr), .dmi_rd(dmi_rd),
        .dmi_wr(dmi_wr), .dmi_wdata(dmi_wdata), .dmi_rdata(dmi_rdata),
        .exec_start(exec_start), .exec_cmd(exec_cmd),
        .exec_done(exec_done), .exec_err(exec_err)
    );

    // Vector: {is_write, addr, wdata, expected read data}
    localparam logic [71:0] VEC [16] = '{
        {1'b1, 7'h04, 32'h1111_1111, 32'h0},
        {1'b1, 7'h05, 32'h2222_2222, 32'h0},
        {1'b1, 7'h07, 32'h4444_4444, 32'h0},
        {1'b1, 7'h08, 32'hDEAD_BEEF, 32'h0},
        {1'b1, 7'h20, 32'hA0A0_A0A0, 32'h0},
        {1'b1, 7'h27, 32'hA7A7_A7A7, 32'h0},
        {1'b1, 7'h28, 32'h5555_5555, 32'h0},
        {1'b0, 7'h04, 32'h0, 32'h1111_1111},
        {1'b0, 7'h05, 32'h0, 32'h2222_2222},
        {1'b0, 7'h06, 32'h0, 32'h0},
        {1'b0, 7'h07, 32'h0, 32'h4444_4444},
        {1'b0, 7'h08, 32'h0, 32'h0},
        {1'b0, 7'h20, 32'h0, 32'hA0A0_A0A0},
        {1'b0, 7'h27, 32'h0, 32'hA7A7_A7A7},
        {1'b0, 7'h28, 32'h0, 32'h0},
        {1'b0, 7'h16, 32'h0, 32'h0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One access; on return the clock edge has passed and exec_start is visible.
    task automatic access(input logic wr, input logic [6:0] a, input logic [31:0] d,
                          output logic [31:0] r);
        @(negedge clk);
        dmi_addr = a; dmi_wr = wr; dmi_rd = !wr; dmi_wdata = d;
        #1 r = dmi_rdata;
        @(posedge clk);
        #1 dmi_wr = 1'b0; dmi_rd = 1'b0;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        access(1'b1, a, d, dummy);
    endtask

    task automatic finish_cmd(input logic fail);
        @(negedge clk);
        exec_done = 1'b1; exec_err = fail;
        @(posedge clk);
        #1 exec_done = 1'b0; exec_err = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1: reset state
        check("R1 exec_start", {31'b0, exec_start}, 32'h0);
        access(1'b0, 7'h04, 0, rv); check("R1 data0", rv, 32'h0);
        access(1'b0, 7'h16, 0, rv); check("R1 cs", rv, 32'h0);
        access(1'b0, 7'h17, 0, rv); check("R1 cmd", rv, 32'h0);

        // R2/R3: table of window accesses, no start may occur
        for (int i = 0; i < 16; i++) begin
            access(VEC[i][71], VEC[i][70:64], VEC[i][63:32], rv);
            if (!VEC[i][71]) check("R2/R3 table read", rv, VEC[i][31:0]);
            check("R3 table no start", {31'b0, exec_start}, 32'h0);
        end

        // R4: command write starts once
        wr(7'h17, 32'h0000_1234);
        check("R4 start", {31'b0, exec_start}, 32'h1);
        check("R4 exec_cmd", exec_cmd, 32'h0000_1234);
        @(posedge clk); #1;
        check("R4 pulse width", {31'b0, exec_start}, 32'h0);
        access(1'b0, 7'h16, 0, rv); check("R7 busy flag", rv, 32'h0000_1000);
        finish_cmd(1'b0);
        access(1'b0, 7'h16, 0, rv); check("R7 busy cleared", rv, 32'h0);

        // R7: start while busy gives busy error
        wr(7'h17, 32'h0000_0042);
        check("R7 first start", {31'b0, exec_start}, 32'h1);
        wr(7'h17, 32'h0000_0099);
        check("R7 no start busy", {31'b0, exec_start}, 32'h0);
        access(1'b0, 7'h16, 0, rv); check("R7 busy err", rv, 32'h0000_1001);
        finish_cmd(1'b0);

        // R8: pending error blocks starts
        wr(7'h17, 32'h0000_0077);
        check("R8 blocked", {31'b0, exec_start}, 32'h0);
        access(1'b0, 7'h16, 0, rv); check("R8 cs", rv, 32'h0000_0001);

        // R9/R6: clear error, load mask bit 1
        wr(7'h16, 32'h0002_0001);
        access(1'b0, 7'h16, 0, rv); check("R9 R6 cs", rv, 32'h0002_0000);

        // R5: autoexec on write and on read of data word 1
        wr(7'h05, 32'h0000_CAFE);
        check("R5 write autoexec", {31'b0, exec_start}, 32'h1);
        finish_cmd(1'b0);
        access(1'b0, 7'h05, 0, rv);
        check("R5 read value", rv, 32'h0000_CAFE);
        check("R5 read autoexec", {31'b0, exec_start}, 32'h1);
        finish_cmd(1'b0);
        access(1'b0, 7'h04, 0, rv);
        check("R5 mask bit clear", {31'b0, exec_start}, 32'h0);

        // R3/R2: full mask, program buffer and out-of-range data never start
        wr(7'h16, 32'h00FF_0000);
        wr(7'h20, 32'h1);
        check("R3 pbuf no start", {31'b0, exec_start}, 32'h0);
        access(1'b0, 7'h08, 0, rv);
        check("R2 beyond data no start", {31'b0, exec_start}, 32'h0);

        // R10: failed completion; R9 partial clear
        wr(7'h17, 32'h0000_0005);
        finish_cmd(1'b1);
        access(1'b0, 7'h16, 0, rv); check("R10 exec err", rv, 32'h00FF_0002);
        wr(7'h16, 32'h00FF_0001);
        access(1'b0, 7'h16, 0, rv); check("R9 partial clear", rv, 32'h00FF_0002);
        wr(7'h16, 32'h00FF_0007);
        access(1'b0, 7'h16, 0, rv); check("R9 full clear", rv, 32'h00FF_0000);

        // R1: reset mid-run clears storage
        do_reset();
        access(1'b0, 7'h05, 0, rv); check("R1 data after reset", rv, 32'h0);
        access(1'b0, 7'h27, 0, rv); check("R1 pbuf after reset", rv, 32'h0);
        access(1'b0, 7'h16, 0, rv); check("R1 cs after reset", rv, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule